// File: doc/BRIEF.md
# Direction-Controlled Pulse Edge Counter

This block counts pulses that arrive on an asynchronous pin and uses a second asynchronous pin to set the direction of each count. A high direction level makes each counted pulse add one, and a low level makes it subtract one. Each pin passes through its own multi-flop synchronizer and a programmable stability filter before any edge is detected. Both paths have the same latency, so the direction level that goes with a pulse edge reaches the counter in the same clock cycle as that edge.

By default only one edge of the pulse pin is counted, and a control bit picks whether that is the rising or the falling edge. A second control bit makes the block count both edges. The edge detector's history register follows the filtered pin level all the time. As a result, enabling the counter, or leaving reset with the pin already high, never produces a count that no real transition caused. A synchronous load strobe presets the count. The count wraps in both directions, and a one-cycle flag marks each wrap.

Top module: `dir_edge_counter`

## Requirements
- R1: With `dirIn` high, each counted pulse edge adds 1 to `count`. With `dirIn` low, it subtracts 1.
- R2: With `bothEdges`=0, only one edge of `pulseIn` is counted: the rising edge when `edgeSel`=0 and the falling edge when `edgeSel`=1. The other edge leaves `count` unchanged.
- R3: With `bothEdges`=1, every filtered transition of `pulseIn` (rising and falling) is counted, and `edgeSel` has no effect.
- R4: The direction level used for an edge is the filtered `dirIn` level in the same cycle. If a change of `dirIn` reaches the pins in the same clock cycle as a pulse edge, that edge counts in the new direction.
- R5: A new pin level is accepted only after it has been stable for N consecutive clocks after synchronization. N is `fltLen`, and the value 0 acts as 1. A level that lasts N-1 clocks is ignored.
- R6: Latency: call the first clock edge that samples a new stable pin level edge 0. Then `count` changes on edge N+2 (two synchronizer stages).
- R7: While `enable`=0, `count` holds its value but the filters keep tracking the pins. Raising `enable` while `pulseIn` is already at its active level causes no count. The next genuine active edge is counted.
- R8: `count` is 16 bits and wraps modulo 2^16. `ovfPulse` is high for exactly one cycle when the count goes from 0xFFFF to 0x0000, and `unfPulse` is high for one cycle when it goes from 0x0000 to 0xFFFF. At all other times the flags stay low.
- R9: `loadStb`=1 writes `loadVal` into `count` on the next clock edge, whatever the state of `enable`. It takes priority over a count event in the same cycle and raises no flag.
- R10: After reset, `count` is 0 and both flags are low. A pin that is already high at the end of reset causes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulseIn | input | 1 | Raw pulse pin, asynchronous |
| dirIn | input | 1 | Raw direction pin, asynchronous (1 = up) |
| enable | input | 1 | Count enable |
| edgeSel | input | 1 | Active edge in single-edge mode (0 rising, 1 falling) |
| bothEdges | input | 1 | 1 = count both edges |
| fltLen | input | 4 | Filter stability length in clocks (0 acts as 1) |
| loadStb | input | 1 | Synchronous preset strobe |
| loadVal | input | 16 | Preset value |
| count | output | 16 | Current count |
| ovfPulse | output | 1 | One-cycle wrap flag, max to 0 |
| unfPulse | output | 1 | One-cycle wrap flag, 0 to max |

## Verification
A table of single pulses is applied under every combination of direction, edge polarity and edge mode, at several filter lengths, including 0 and 15. The count is checked in the middle of each pulse and again at its end. The mid-pulse check separates rising-edge counting from falling-edge counting from both-edge counting, and the end check confirms the sign of each step. Directed patterns follow:
- A pulse one clock shorter than the filter length, and one exactly as long, check the acceptance boundary.
- A direction flip that arrives together with a rising edge checks that the edge uses the new direction.
- A load timed onto the exact cycle of a count event checks load priority.
- Enabling the counter, and leaving reset, with the pin already high checks that no count occurs without a real transition.

// File: rtl/dec_pkg.sv
package dec_pkg;

  // Strobes the control half issues to the datapath each cycle.
  typedef struct packed {
    logic load;   // preset the count from loadVal
    logic inc;    // count event, upward
    logic dec;    // count event, downward
  } cntStb_t;

endpackage

// File: rtl/dec_in_cond.sv
// Input conditioner: multi-stage synchronizer followed by a stability filter.
// The filtered level is seeded straight from the synchronizer after reset,
// and 'settled' rises one cycle after that seed so downstream history is valid.
module dec_in_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FLT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rawIn,
  input  logic [FLT_W-1:0] fltLen,
  output logic             fltOut,
  output logic             settled
);

  localparam int SETTLE_CYC = SYNC_STAGES + 2;
  localparam int SETTLE_W   = $clog2(SETTLE_CYC + 1);

  logic             syncLast;
  logic [FLT_W-1:0] stableCnt;
  logic [FLT_W-1:0] nextCnt;
  logic [FLT_W-1:0] effLen;
  logic [SETTLE_W-1:0] settleCnt;

  // Synchronizer chain; the depth parameter picks the structure.
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= 1'b0;
        else        syncQ <= rawIn;
      end
      assign syncLast = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      end
      assign syncLast = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // Settle counter after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      settleCnt <= '0;
    else if (settleCnt != SETTLE_W'(SETTLE_CYC))
      settleCnt <= settleCnt + 1'b1;
  end

  assign settled = (settleCnt == SETTLE_W'(SETTLE_CYC));

  // A length of zero is treated as one clock.
  assign effLen  = (fltLen == '0) ? FLT_W'(1) : fltLen;
  assign nextCnt = stableCnt + 1'b1;

  // Stability filter.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fltOut    <= 1'b0;
      stableCnt <= '0;
    end else if (!settled) begin
      fltOut    <= syncLast;
      stableCnt <= '0;
    end else if (syncLast == fltOut) begin
      stableCnt <= '0;
    end else if (nextCnt >= effLen) begin
      fltOut    <= syncLast;
      stableCnt <= '0;
    end else begin
      stableCnt <= nextCnt;
    end
  end

  // Once settled, a change of the filtered level must carry the synchronized level.
  AST_FLT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && $past(settled) && !$stable(fltOut)) |-> (fltOut == $past(syncLast))) // R5
    else $error("filter output changed to a value the synchronizer did not hold");

endmodule

// File: rtl/dec_ctrl.sv
// Control half: edge detection on the filtered pulse level, direction sampling,
// enable gating and load arbitration into a strobe struct.
module dec_ctrl
  import dec_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fltPulse,
  input  logic    fltDir,
  input  logic    ready,
  input  logic    enable,
  input  logic    edgeSel,
  input  logic    bothEdges,
  input  logic    loadStb,
  output cntStb_t stb
);

  logic prevPulse;
  logic riseEdge;
  logic fallEdge;
  logic edgeHit;
  logic countEvt;

  // The history follows the filtered level every cycle, whether or not counting
  // is enabled, so turning on the counter never sees a stale level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevPulse <= 1'b0;
    else        prevPulse <= fltPulse;
  end

  assign riseEdge = fltPulse & ~prevPulse;
  assign fallEdge = ~fltPulse & prevPulse;

  always_comb begin
    if (bothEdges)    edgeHit = riseEdge | fallEdge;
    else if (edgeSel) edgeHit = fallEdge;
    else              edgeHit = riseEdge;
  end

  assign countEvt = edgeHit & enable & ready;

  always_comb begin
    stb      = '0;
    stb.load = loadStb;
    stb.inc  = countEvt & fltDir;
    stb.dec  = countEvt & ~fltDir;
  end

  // A count strobe implies that the filtered level just moved away from history.
  AST_EVT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.inc || stb.dec) |-> (fltPulse != prevPulse)) // R7
    else $error("count strobe without a filtered transition");

  AST_NO_EVT_UNSETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !(stb.inc || stb.dec)) // R10
    else $error("count strobe before inputs settled");

endmodule

// File: rtl/dec_datapath.sv
// Datapath half: the count register with wrap flags.
module dec_datapath
  import dec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cntStb_t          stb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             ovfPulse,
  output logic             unfPulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      ovfPulse <= 1'b0;
      unfPulse <= 1'b0;
    end else begin
      ovfPulse <= 1'b0;
      unfPulse <= 1'b0;
      if (stb.load) begin
        count <= loadVal;
      end else if (stb.inc) begin
        count    <= count + 1'b1;
        ovfPulse <= (count == CNT_MAX);
      end else if (stb.dec) begin
        count    <= count - 1'b1;
        unfPulse <= (count == '0);
      end
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load |=> (count == $past(loadVal) && !ovfPulse && !unfPulse)) // R9
    else $error("load did not take priority");

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.load || stb.inc || stb.dec) |=> $stable(count)) // R7
    else $error("count moved without a strobe");

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovfPulse |-> (count == '0 && $past(count) == CNT_MAX)) // R8
    else $error("overflow flag without max-to-zero wrap");

  AST_UNF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    unfPulse |-> (count == CNT_MAX && $past(count) == '0)) // R8
    else $error("underflow flag without zero-to-max wrap");

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.inc && !stb.load) |=> (count == $past(count) + 1'b1)) // R1
    else $error("upward event did not add one");

endmodule

// File: rtl/dir_edge_counter.sv
// Thin top: two input conditioners, the control half and the datapath.
module dir_edge_counter
  import dec_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FLT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulseIn,
  input  logic             dirIn,
  input  logic             enable,
  input  logic             edgeSel,
  input  logic             bothEdges,
  input  logic [FLT_W-1:0] fltLen,
  input  logic             loadStb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             ovfPulse,
  output logic             unfPulse
);

  logic    fltPulse;
  logic    fltDir;
  logic    pulseSettled;
  logic    dirSettled;
  cntStb_t stb;

  dec_in_cond #(.SYNC_STAGES(SYNC_STAGES), .FLT_W(FLT_W)) pulseCond_i (
    .clk(clk), .rst_n(rst_n), .rawIn(pulseIn), .fltLen(fltLen),
    .fltOut(fltPulse), .settled(pulseSettled)
  );

  dec_in_cond #(.SYNC_STAGES(SYNC_STAGES), .FLT_W(FLT_W)) dirCond_i (
    .clk(clk), .rst_n(rst_n), .rawIn(dirIn), .fltLen(fltLen),
    .fltOut(fltDir), .settled(dirSettled)
  );

  dec_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .fltPulse(fltPulse), .fltDir(fltDir),
    .ready(pulseSettled & dirSettled), .enable(enable), .edgeSel(edgeSel),
    .bothEdges(bothEdges), .loadStb(loadStb), .stb(stb)
  );

  dec_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .loadVal(loadVal),
    .count(count), .ovfPulse(ovfPulse), .unfPulse(unfPulse)
  );

endmodule

// File: tb/dir_edge_counter_tb_top.sv
`timescale 1ns/1ps
module dir_edge_counter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulseIn = 1'b0;
  logic        dirIn = 1'b0;
  logic        enable = 1'b1;
  logic        edgeSel = 1'b0;
  logic        bothEdges = 1'b0;
  logic [3:0]  fltLen = 4'd1;
  logic        loadStb = 1'b0;
  logic [15:0] loadVal = '0;
  logic [15:0] count;
  logic        ovfPulse;
  logic        unfPulse;

  int checks = 0;
  int fails = 0;
  int ovfSeen = 0;
  int unfSeen = 0;
  logic [15:0] expCnt;

  localparam int HOLD = 24;

  always #2 clk = ~clk;  // 250 MHz

  dir_edge_counter dut_i (
    .clk(clk), .rst_n(rst_n), .pulseIn(pulseIn), .dirIn(dirIn), .enable(enable),
    .edgeSel(edgeSel), .bothEdges(bothEdges), .fltLen(fltLen), .loadStb(loadStb),
    .loadVal(loadVal), .count(count), .ovfPulse(ovfPulse), .unfPulse(unfPulse)
  );

  always @(negedge clk) begin
    if (ovfPulse) ovfSeen++;
    if (unfPulse) unfSeen++;
  end

  // Vector: [12] dir, [11] edgeSel, [10] bothEdges, [9:6] fltLen,
  //         [5:3] step after the rising half (signed), [2:0] step after the whole pulse (signed)
  localparam int NVEC = 8;
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 4'd1,  3'b001, 3'b001},  // R1 R2 up, rising
    {1'b0, 1'b0, 1'b0, 4'd2,  3'b111, 3'b111},  // R1 R2 down, rising
    {1'b1, 1'b1, 1'b0, 4'd3,  3'b000, 3'b001},  // R2 up, falling
    {1'b0, 1'b1, 1'b0, 4'd4,  3'b000, 3'b111},  // R2 down, falling
    {1'b1, 1'b0, 1'b1, 4'd1,  3'b001, 3'b010},  // R3 up, both edges
    {1'b0, 1'b1, 1'b1, 4'd5,  3'b111, 3'b110},  // R3 down, both edges, edgeSel ignored
    {1'b1, 1'b0, 1'b0, 4'd15, 3'b001, 3'b001},  // R5 longest filter
    {1'b0, 1'b1, 1'b0, 4'd0,  3'b000, 3'b111}   // R5 zero acts as one
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doLoad(input logic [15:0] v);
    @(negedge clk);
    loadVal = v;
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic fullPulse();
    @(negedge clk); pulseIn = 1'b1;
    waitCyc(HOLD);
    @(negedge clk); pulseIn = 1'b0;
    waitCyc(HOLD);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int o0;
    int u0;
    waitCyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 count after reset", count, 16'h0000);
    check("R10 flags after reset", {15'b0, ovfPulse | unfPulse}, 16'h0000);
    waitCyc(10);

    // Vector table
    doLoad(16'h8000);
    expCnt = 16'h8000;
    o0 = ovfSeen; u0 = unfSeen;
    for (int i = 0; i < NVEC; i++) begin
      logic [12:0] v;
      v = VEC[i];
      @(negedge clk);
      dirIn = v[12]; edgeSel = v[11]; bothEdges = v[10]; fltLen = v[9:6];
      waitCyc(HOLD);
      @(negedge clk); pulseIn = 1'b1;
      waitCyc(HOLD);
      check("R1 R2 R3 mid-pulse count", count, expCnt + 16'($signed(v[5:3])));
      @(negedge clk); pulseIn = 1'b0;
      waitCyc(HOLD);
      expCnt = expCnt + 16'($signed(v[2:0]));
      check("R1 R2 R3 end-of-pulse count", count, expCnt);
    end
    check("R8 no flags away from wrap", 16'(ovfSeen - o0 + unfSeen - u0), 16'd0);

    // R5 filter boundary, N=4
    @(negedge clk); dirIn = 1'b1; edgeSel = 1'b0; bothEdges = 1'b0; fltLen = 4'd4;
    waitCyc(HOLD);
    @(negedge clk); pulseIn = 1'b1;
    waitCyc(2);
    @(negedge clk); pulseIn = 1'b0;
    waitCyc(HOLD);
    check("R5 pulse of N-1 clocks ignored", count, expCnt);
    @(negedge clk); pulseIn = 1'b1;
    waitCyc(3);
    @(negedge clk); pulseIn = 1'b0;
    waitCyc(HOLD);
    expCnt = expCnt + 1'b1;
    check("R5 pulse of N clocks counted", count, expCnt);

    // R6 latency, N=2
    @(negedge clk); fltLen = 4'd2;
    waitCyc(HOLD);
    @(negedge clk); pulseIn = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R6 count not yet moved at edge N+1", count, expCnt);
    @(posedge clk);
    @(negedge clk);
    expCnt = expCnt + 1'b1;
    check("R6 count moved at edge N+2", count, expCnt);
    @(negedge clk); pulseIn = 1'b0;
    waitCyc(HOLD);

    // R4 direction flip arriving with the rising edge
    @(negedge clk); dirIn = 1'b0;
    waitCyc(HOLD);
    @(negedge clk); dirIn = 1'b1; pulseIn = 1'b1;
    waitCyc(HOLD);
    expCnt = expCnt + 1'b1;
    check("R4 new direction honoured on same edge", count, expCnt);
    @(negedge clk); pulseIn = 1'b0;
    waitCyc(HOLD);

    // R9 load on the exact cycle of a count event, N=1
    @(negedge clk); fltLen = 4'd1;
    waitCyc(HOLD);
    @(negedge clk); pulseIn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); loadVal = 16'h1234; loadStb = 1'b1;
    @(negedge clk); loadStb = 1'b0;
    waitCyc(HOLD);
    check("R9 load beats same-cycle count", count, 16'h1234);
    @(negedge clk); pulseIn = 1'b0;
    waitCyc(HOLD);

    // R8 overflow
    doLoad(16'hFFFF);
    o0 = ovfSeen; u0 = unfSeen;
    fullPulse();
    check("R8 wrap max to zero", count, 16'h0000);
    check("R8 one overflow flag", 16'(ovfSeen - o0), 16'd1);
    check("R8 no underflow on overflow", 16'(unfSeen - u0), 16'd0);

    // R8 underflow
    @(negedge clk); dirIn = 1'b0;
    waitCyc(HOLD);
    o0 = ovfSeen; u0 = unfSeen;
    fullPulse();
    check("R8 wrap zero to max", count, 16'hFFFF);
    check("R8 one underflow flag", 16'(unfSeen - u0), 16'd1);
    check("R8 no overflow on underflow", 16'(ovfSeen - o0), 16'd0);

    // R7 hold while disabled, R9 load while disabled
    @(negedge clk); enable = 1'b0; dirIn = 1'b1;
    waitCyc(HOLD);
    fullPulse();
    check("R7 count holds while disabled", count, 16'hFFFF);
    doLoad(16'h00AA);
    check("R9 load works while disabled", count, 16'h00AA);

    // R7 enable with pin already at its active level
    @(negedge clk); pulseIn = 1'b1;
    waitCyc(HOLD);
    @(negedge clk); enable = 1'b1;
    waitCyc(HOLD);
    check("R7 no false count on enable", count, 16'h00AA);
    @(negedge clk); pulseIn = 1'b0;
    waitCyc(HOLD);
    check("R7 inactive edge after enable ignored", count, 16'h00AA);
    @(negedge clk); pulseIn = 1'b1;
    waitCyc(HOLD);
    check("R7 next genuine edge counted", count, 16'h00AB);

    // R10 pin high through reset
    @(negedge clk); rst_n = 1'b0;
    waitCyc(3);
    @(negedge clk); rst_n = 1'b1;
    waitCyc(HOLD);
    check("R10 pin high at reset causes no count", count, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule